// File: doc/BRIEF.md
# Receive Buffer Ring Fetch Unit

This block looks after the ring of receive buffer descriptors that a network receiver works through. Each ring entry holds four 16-bit words naming one receive buffer: a 32-bit buffer address and a 32-bit length in 16-bit words. On request the block reads the entry under its read pointer through a one-word-at-a-time memory read port. It then loads the current buffer address and remaining word count, and steps the read pointer around the ring.

Three events ask for a fetch. Software can issue a fetch command. Software can clear the exhaustion flag. A received packet can leave less room in the current buffer than the low-water mark. Software keeps a write pointer that marks the last entry it has handed over. When the read pointer reaches that write pointer the block raises the exhaustion flag and tells the receiver to stop accepting frames. Only one fetch runs at a time. A request that arrives during a fetch is held and served after it.

Top module: `rrm_ring_mgr`

## Requirements
- R1: After reset the start, end, read, write and upper-address registers read 0 and the low-water mark reads 0x02F8. No fetch is pending and no memory request is made. The exhaustion flag is clear, the receive-ready output is high, and the buffer address and word count are 0.
- R2: Register select codes are 0 start, 1 end, 2 read pointer, 3 write pointer, 4 upper address, 5 low-water mark, and `reg_rdata` returns the selected register. A write to codes 0 to 3 stores the data with bit 0 forced to 0. Codes 4 and 5 store all 16 bits.
- R3: A fetch reads four words, one request at a time, from byte address {upper, read pointer} plus an offset. The offsets are 0, 2, 4 and 6 in 16-bit mode and 0, 4, 8 and 12 in 32-bit mode. The address and request stay stable until `mem_ack`.
- R4: The four words are, in read order, buffer address low, buffer address high, word count low and word count high. `buf_ptr` and `word_cnt` change only in the cycle the fourth word is accepted, together with the read pointer.
- R5: At fetch completion the read pointer advances by 8, or by 16 in 32-bit mode. If the result equals the end register, it is replaced by the start register.
- R6: If the read pointer after advance and wrap equals the write pointer, `exhausted` is set and `rx_ready` goes low.
- R7: A clear pulse while `exhausted` is set clears the flag and launches a fetch on the next clock edge. A clear pulse while the flag is already clear launches nothing.
- R8: `cmd_busy` goes high on the clock edge that accepts a fetch request and stays high until the last fetch completes.
- R9: On `pkt_done` the word count decreases by (`pkt_len` + 4) / 2, using integer division. If the result is below the low-water mark, `last_pkt` is set and a fetch is requested. Otherwise `last_pkt` is cleared.
- R10: A request that arrives while a fetch is busy is held. It is served by a second fetch right after the first completes, and `cmd_busy` does not drop in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register value |
| wide_mode | input | 1 | 1 selects 32-bit descriptor spacing |
| fetch_cmd | input | 1 | Fetch command pulse |
| exhaust_clr | input | 1 | Write-one-to-clear pulse for the exhaustion flag |
| pkt_done | input | 1 | A packet was stored in the current buffer |
| pkt_len | input | 16 | Byte length of that packet |
| cmd_busy | output | 1 | Fetch command pending or running |
| exhausted | output | 1 | Ring resources exhausted |
| rx_ready | output | 1 | Receiver may accept frames |
| last_pkt | output | 1 | Remaining count fell below the low-water mark |
| buf_ptr | output | 32 | Current receive buffer address |
| word_cnt | output | 32 | Remaining words in the current buffer |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Memory byte address |
| mem_ack | input | 1 | Read word returned this cycle |
| mem_rdata | input | 16 | Read word |

## Verification
The bench builds the block with its default 16-bit word width and a low-water mark of 0x02F8 after reset. With these values a ring of only three narrow entries, reached by byte-sized pointer values, brings wrap-around, exhaustion and the held second request into reach within a few fetches. The word-count comparison is exercised by moving the low-water mark just above the count the bench loaded. The memory responder returns an address-derived word and can insert idle cycles between acknowledges, so the stability of a pending request is also exercised.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    // Register select codes (R2)
    typedef enum logic [2:0] {
        SEL_START   = 3'd0,
        SEL_END     = 3'd1,
        SEL_RDPTR   = 3'd2,
        SEL_WRPTR   = 3'd3,
        SEL_UPPER   = 3'd4,
        SEL_LOWMARK = 3'd5
    } rrm_sel_e;

    localparam int unsigned DESC_WORDS = 4;

endpackage

// File: rtl/rrm_ptr_regs.sv
module rrm_ptr_regs
    import rrm_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter logic [15:0] LOWMARK_RST = 16'h02F8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              adv_en,
    input  logic [WORD_W-1:0] adv_value,
    output logic [WORD_W-1:0] start_ptr,
    output logic [WORD_W-1:0] end_ptr,
    output logic [WORD_W-1:0] rd_ptr,
    output logic [WORD_W-1:0] wr_ptr,
    output logic [WORD_W-1:0] upper,
    output logic [WORD_W-1:0] lowmark,
    output logic [WORD_W-1:0] rdata
);
    typedef struct packed {
        logic [WORD_W-1:0] start_p;
        logic [WORD_W-1:0] end_p;
        logic [WORD_W-1:0] rd_p;
        logic [WORD_W-1:0] wr_p;
        logic [WORD_W-1:0] upper;
        logic [WORD_W-1:0] lowmark;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [WORD_W-1:0] even_data;
    rrm_sel_e sel_e;

    assign sel_e     = rrm_sel_e'(sel);
    assign even_data = {wdata[WORD_W-1:1], 1'b0};   // R2: pointer bit 0 forced low

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (sel_e)
                SEL_START:   regs_d.start_p = even_data;
                SEL_END:     regs_d.end_p   = even_data;
                SEL_RDPTR:   regs_d.rd_p    = even_data;
                SEL_WRPTR:   regs_d.wr_p    = even_data;
                SEL_UPPER:   regs_d.upper   = wdata;
                SEL_LOWMARK: regs_d.lowmark = wdata;
                default: ;
            endcase
        end
        if (adv_en) begin
            regs_d.rd_p = adv_value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q         <= '0;
            regs_q.lowmark <= WORD_W'(LOWMARK_RST);
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (sel_e)
            SEL_START:   rdata = regs_q.start_p;
            SEL_END:     rdata = regs_q.end_p;
            SEL_RDPTR:   rdata = regs_q.rd_p;
            SEL_WRPTR:   rdata = regs_q.wr_p;
            SEL_UPPER:   rdata = regs_q.upper;
            SEL_LOWMARK: rdata = regs_q.lowmark;
            default:     rdata = '0;
        endcase
    end

    assign start_ptr = regs_q.start_p;
    assign end_ptr   = regs_q.end_p;
    assign rd_ptr    = regs_q.rd_p;
    assign wr_ptr    = regs_q.wr_p;
    assign upper     = regs_q.upper;
    assign lowmark   = regs_q.lowmark;
endmodule

// File: rtl/rrm_ring_step.sv
module rrm_ring_step #(
    parameter int unsigned WORD_W = 16
) (
    input  logic [WORD_W-1:0] rd_ptr,
    input  logic [WORD_W-1:0] start_ptr,
    input  logic [WORD_W-1:0] end_ptr,
    input  logic [WORD_W-1:0] wr_ptr,
    input  logic              wide,
    output logic [WORD_W-1:0] next_rd,
    output logic              hits_wr
);
    localparam int unsigned STEP_NARROW = rrm_pkg::DESC_WORDS * 2;
    localparam int unsigned STEP_WIDE   = rrm_pkg::DESC_WORDS * 4;

    logic [WORD_W-1:0] stepped;

    always_comb begin
        stepped = rd_ptr + (wide ? WORD_W'(STEP_WIDE) : WORD_W'(STEP_NARROW)); // R5
        next_rd = (stepped == end_ptr) ? start_ptr : stepped;                 // R5 wrap
        hits_wr = (next_rd == wr_ptr);                                        // R6
    end
endmodule

// File: rtl/rrm_fetch_seq.sv
module rrm_fetch_seq #(
    parameter int unsigned WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [2*WORD_W-1:0] base,
    input  logic                wide_in,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                mem_req,
    output logic [2*WORD_W-1:0] mem_addr,
    output logic                busy,
    output logic                done,
    output logic                wide_q,
    output logic [2*WORD_W-1:0] desc_buf,
    output logic [2*WORD_W-1:0] desc_cnt
);
    localparam int unsigned AW    = 2 * WORD_W;
    localparam int unsigned HOLD  = rrm_pkg::DESC_WORDS - 1;
    localparam int unsigned IDX_W = $clog2(rrm_pkg::DESC_WORDS);

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic              wide;
        logic [AW-1:0]     base;
        logic [HOLD*WORD_W-1:0] words;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        done  = 1'b0;
        if (!seq_q.busy) begin
            if (launch) begin
                seq_d.busy = 1'b1;
                seq_d.idx  = '0;
                seq_d.wide = wide_in;
                seq_d.base = base;
            end
        end else if (mem_ack) begin
            if (seq_q.idx == IDX_W'(HOLD)) begin
                seq_d.busy = 1'b0;
                done       = 1'b1;          // R4: results commit in this cycle
            end else begin
                seq_d.words[seq_q.idx*WORD_W +: WORD_W] = mem_rdata;
                seq_d.idx = seq_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    // R3: word offset 2 bytes narrow, 4 bytes wide
    assign mem_addr = seq_q.base + (seq_q.wide ? AW'({seq_q.idx, 2'b00})
                                               : AW'({seq_q.idx, 1'b0}));
    assign mem_req  = seq_q.busy;
    assign busy     = seq_q.busy;
    assign wide_q   = seq_q.wide;
    assign desc_buf = seq_q.words[2*WORD_W-1:0];
    assign desc_cnt = {mem_rdata, seq_q.words[3*WORD_W-1:2*WORD_W]};
endmodule

// File: rtl/rrm_ring_mgr.sv
module rrm_ring_mgr #(
    parameter int unsigned WORD_W      = 16,
    parameter logic [15:0] LOWMARK_RST = 16'h02F8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [2:0]          reg_sel,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic                wide_mode,
    input  logic                fetch_cmd,
    input  logic                exhaust_clr,
    input  logic                pkt_done,
    input  logic [15:0]         pkt_len,
    output logic                cmd_busy,
    output logic                exhausted,
    output logic                rx_ready,
    output logic                last_pkt,
    output logic [2*WORD_W-1:0] buf_ptr,
    output logic [2*WORD_W-1:0] word_cnt,
    output logic                mem_req,
    output logic [2*WORD_W-1:0] mem_addr,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata
);
    localparam int unsigned CW = 2 * WORD_W;

    typedef struct packed {
        logic          pending;
        logic          exh;
        logic          last;
        logic [CW-1:0] bptr;
        logic [CW-1:0] cnt;
    } top_t;

    top_t st_d, st_q;

    logic [WORD_W-1:0] start_ptr, end_ptr, rd_ptr, wr_ptr, upper, lowmark;
    logic [WORD_W-1:0] next_rd;
    logic              hits_wr;
    logic              fetch_busy, fetch_done, fetch_wide, launch;
    logic [CW-1:0]     desc_buf, desc_cnt;
    logic [CW-1:0]     pkt_dec, remaining;
    logic              low_hit, new_req;

    rrm_ptr_regs #(.WORD_W(WORD_W), .LOWMARK_RST(LOWMARK_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .sel(reg_sel), .wdata(reg_wdata),
        .adv_en(fetch_done), .adv_value(next_rd),
        .start_ptr(start_ptr), .end_ptr(end_ptr), .rd_ptr(rd_ptr),
        .wr_ptr(wr_ptr), .upper(upper), .lowmark(lowmark), .rdata(reg_rdata)
    );

    rrm_ring_step #(.WORD_W(WORD_W)) u_step (
        .rd_ptr(rd_ptr), .start_ptr(start_ptr), .end_ptr(end_ptr),
        .wr_ptr(wr_ptr), .wide(fetch_wide),
        .next_rd(next_rd), .hits_wr(hits_wr)
    );

    rrm_fetch_seq #(.WORD_W(WORD_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .base({upper, rd_ptr}), .wide_in(wide_mode),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .busy(fetch_busy), .done(fetch_done), .wide_q(fetch_wide),
        .desc_buf(desc_buf), .desc_cnt(desc_cnt)
    );

    always_comb begin
        st_d      = st_q;
        // R9: consumed words = (bytes + 4) / 2
        pkt_dec   = (CW'(pkt_len) + CW'(4)) >> 1;
        remaining = st_q.cnt - pkt_dec;
        low_hit   = pkt_done && (remaining < CW'(lowmark));
        // R7: a clear only requests a fetch while the flag is set
        new_req   = fetch_cmd || (exhaust_clr && st_q.exh) || low_hit;
        // R10: one fetch at a time, later requests held
        launch    = !fetch_busy && (st_q.pending || new_req);
        st_d.pending = fetch_busy && (st_q.pending || new_req);

        if (pkt_done) begin
            st_d.cnt  = remaining;
            st_d.last = low_hit;
        end
        if (exhaust_clr) begin
            st_d.exh = 1'b0;
        end
        if (fetch_done) begin            // R4: atomic commit
            st_d.bptr = desc_buf;
            st_d.cnt  = desc_cnt;
            if (hits_wr) st_d.exh = 1'b1; // R6
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_busy  = fetch_busy || st_q.pending;   // R8
    assign exhausted = st_q.exh;
    assign rx_ready  = !st_q.exh;
    assign last_pkt  = st_q.last;
    assign buf_ptr   = st_q.bptr;
    assign word_cnt  = st_q.cnt;
endmodule

// File: rtl/rrm_ring_mgr_chk.sv
module rrm_ring_mgr_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mem_req,
    input logic                mem_ack,
    input logic [2*WORD_W-1:0] mem_addr,
    input logic                cmd_busy,
    input logic                reg_wr_en,
    input logic [WORD_W-1:0]   rd_ptr,
    input logic [WORD_W-1:0]   start_ptr,
    input logic [WORD_W-1:0]   end_ptr,
    input logic                exhausted,
    input logic                fetch_done
);
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_req_flags_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cmd_busy);

    assert_rd_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr[0] == 1'b0);

    assert_wrap_never_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_ptr != $past(rd_ptr)) && !$past(reg_wr_en))
            |-> ((rd_ptr != end_ptr) || (start_ptr == end_ptr)));

    assert_exh_from_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exhausted) |-> $past(fetch_done));
endmodule

bind rrm_ring_mgr rrm_ring_mgr_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .cmd_busy(cmd_busy), .reg_wr_en(reg_wr_en),
    .rd_ptr(rd_ptr), .start_ptr(start_ptr), .end_ptr(end_ptr),
    .exhausted(exhausted), .fetch_done(fetch_done)
);

// File: tb/rrm_ring_mgr_bench.sv
module rrm_ring_mgr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        wide_mode = 1'b0;
    logic        fetch_cmd = 1'b0;
    logic        exhaust_clr = 1'b0;
    logic        pkt_done = 1'b0;
    logic [15:0] pkt_len = '0;
    logic        cmd_busy, exhausted, rx_ready, last_pkt;
    logic [31:0] buf_ptr, word_cnt;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    int tests = 0;
    int fails = 0;
    logic        gap_mode = 1'b0;
    logic        tog = 1'b0;
    logic [31:0] addr_log [16];
    int          log_n = 0;

    always #10 clk = ~clk;   // 50 MHz

    rrm_ring_mgr u_rrm_ring_mgr (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wide_mode(wide_mode),
        .fetch_cmd(fetch_cmd), .exhaust_clr(exhaust_clr), .pkt_done(pkt_done),
        .pkt_len(pkt_len), .cmd_busy(cmd_busy), .exhausted(exhausted),
        .rx_ready(rx_ready), .last_pkt(last_pkt), .buf_ptr(buf_ptr),
        .word_cnt(word_cnt), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory contents: count-high slot reads 0, others address-derived
    function automatic logic [15:0] mem_word(input logic [31:0] a, input logic wide);
        logic [1:0] slot;
        slot = wide ? a[3:2] : a[2:1];
        return (slot == 2'd3) ? 16'h0000 : (a[15:0] ^ 16'h5A00);
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !(gap_mode && tog)) begin
                mem_ack   = 1'b1;
                mem_rdata = mem_word(mem_addr, wide_mode);
                if (log_n < 16) addr_log[log_n] = mem_addr;
                log_n++;
            end else begin
                mem_ack = 1'b0;
            end
            tog = ~tog;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] s, output logic [15:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_fetch();
        @(negedge clk); fetch_cmd = 1'b1;
        @(negedge clk); fetch_cmd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); exhaust_clr = 1'b1;
        @(negedge clk); exhaust_clr = 1'b0;
    endtask

    task automatic pulse_pkt(input logic [15:0] len);
        @(negedge clk); pkt_len = len; pkt_done = 1'b1;
        @(negedge clk); pkt_done = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (cmd_busy && n < 200) begin
            @(negedge clk);
            n++;
        end
        #2;
    endtask

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] wdata;
        logic [15:0] expect_v;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 16'h0101, 16'h0100},
        '{3'd1, 16'h0119, 16'h0118},
        '{3'd2, 16'hFFFF, 16'hFFFE},
        '{3'd3, 16'h0111, 16'h0110},
        '{3'd4, 16'h0012, 16'h0012},
        '{3'd5, 16'h1235, 16'h1235},
        '{3'd2, 16'h0101, 16'h0100},
        '{3'd5, 16'h02F8, 16'h02F8}
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(3'd5, rv);  check_eq("R1 lowmark", {16'h0, rv}, 32'h02F8);
        rd_reg(3'd2, rv);  check_eq("R1 rd ptr", {16'h0, rv}, 32'h0);
        rd_reg(3'd4, rv);  check_eq("R1 upper", {16'h0, rv}, 32'h0);
        check_eq("R1 idle", {29'h0, cmd_busy, mem_req, exhausted}, 32'h0);
        check_eq("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
        check_eq("R1 buf/cnt", buf_ptr | word_cnt, 32'h0);

        // R2 register table
        for (int i = 0; i < 8; i++) begin
            wr_reg(VECS[i].sel, VECS[i].wdata);
            rd_reg(VECS[i].sel, rv);
            check_eq("R2 reg write", {16'h0, rv}, {16'h0, VECS[i].expect_v});
        end

        // T1: narrow fetch with ack gaps (R3 R4 R5 R8)
        gap_mode = 1'b1; log_n = 0;
        pulse_fetch();
        check_eq("R8 cmd_busy after request", {31'h0, cmd_busy}, 32'h1);
        @(negedge clk); @(negedge clk);
        check_eq("R4 no early buf update", buf_ptr, 32'h0);
        check_eq("R4 no early cnt update", word_cnt, 32'h0);
        wait_idle();
        check_eq("R3 narrow word count", log_n, 4);
        for (int k = 0; k < 4; k++)
            check_eq("R3 narrow address", addr_log[k], 32'h00120100 + 32'(2*k));
        check_eq("R4 buf_ptr", buf_ptr, {mem_word(32'h102, 1'b0), mem_word(32'h100, 1'b0)});
        check_eq("R4 word_cnt", word_cnt, {16'h0, mem_word(32'h104, 1'b0)});
        rd_reg(3'd2, rv); check_eq("R5 narrow advance", {16'h0, rv}, 32'h0108);
        check_eq("R6 not exhausted", {31'h0, exhausted}, 32'h0);
        gap_mode = 1'b0;

        // T2: reaching the write pointer (R6)
        pulse_fetch(); wait_idle();
        rd_reg(3'd2, rv); check_eq("R6 rd at wr", {16'h0, rv}, 32'h0110);
        check_eq("R6 exhausted", {31'h0, exhausted}, 32'h1);
        check_eq("R6 rx_ready low", {31'h0, rx_ready}, 32'h0);

        // T3: clear launches fetch, wrap (R7 R5)
        log_n = 0;
        pulse_clr();
        check_eq("R7 clear launches", {31'h0, cmd_busy}, 32'h1);
        check_eq("R7 flag cleared", {31'h0, exhausted}, 32'h0);
        wait_idle();
        rd_reg(3'd2, rv); check_eq("R5 wrap to start", {16'h0, rv}, 32'h0100);
        check_eq("R7 one fetch", log_n, 4);

        // T4: clear while not exhausted does nothing (R7)
        log_n = 0;
        pulse_clr();
        check_eq("R7 idle clear no fetch", {31'h0, cmd_busy}, 32'h0);
        @(negedge clk);
        check_eq("R7 idle clear no reads", log_n, 0);

        // T5: held request (R10)
        log_n = 0;
        pulse_fetch();
        pulse_fetch();
        wait_idle();
        check_eq("R10 two fetches", log_n, 8);
        rd_reg(3'd2, rv); check_eq("R10 rd advanced twice", {16'h0, rv}, 32'h0110);
        check_eq("R10 second hit wr", {31'h0, exhausted}, 32'h1);
        pulse_clr(); wait_idle();

        // T6: wide mode (R3 R5)
        wr_reg(3'd3, 16'h0000);
        wide_mode = 1'b1; log_n = 0;
        pulse_fetch(); wait_idle();
        for (int k = 0; k < 4; k++)
            check_eq("R3 wide address", addr_log[k], 32'h00120100 + 32'(4*k));
        rd_reg(3'd2, rv); check_eq("R5 wide advance", {16'h0, rv}, 32'h0110);
        check_eq("R4 wide word_cnt", word_cnt, 32'h00005B08);
        wide_mode = 1'b0;

        // T7: packet accounting (R9)
        pulse_pkt(16'd1000);
        check_eq("R9 count after 1000", word_cnt, 32'h00005912);
        check_eq("R9 no last", {30'h0, last_pkt, cmd_busy}, 32'h0);
        wr_reg(3'd5, 16'h5900);
        pulse_pkt(16'd27);
        check_eq("R9 odd length", word_cnt, 32'h00005903);
        check_eq("R9 still above mark", {31'h0, last_pkt}, 32'h0);
        pulse_pkt(16'd8);
        check_eq("R9 below mark", word_cnt, 32'h000058FD);
        check_eq("R9 last and fetch", {30'h0, last_pkt, cmd_busy}, 32'h3);
        wait_idle();
        rd_reg(3'd2, rv); check_eq("R9 refetch wrap", {16'h0, rv}, 32'h0100);
        check_eq("R9 count reloaded", word_cnt, {16'h0, mem_word(32'h114, 1'b0)});

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule